// File: doc/BRIEF.md
# NAND Host Bridge with Mode Register

This block connects a 16-bit register-mapped host bus to an 8-bit NAND flash device. The host writes a single mode byte whose bits drive the flash control lines (chip enable, command latch, address latch, write protect release, power and checker controls). It then moves data through a data register. A 16-bit data access becomes two ordered byte cycles on the flash bus, and an 8-bit access becomes one. The block generates the read and write strobes itself, with a low time set by a parameter.

The flash ready/busy line is synchronised into the clock domain. Its inverse appears as a busy flag in the status register. A rising edge of the line latches a ready-request bit in an interrupt status register. The interrupt output is raised while any latched bit is also enabled in the interrupt mask register. The host clears latched bits by writing ones to them.

The host bus uses a one-cycle request pulse and a one-cycle acknowledge pulse that carries read data. The block accepts a request only when no data transfer is in flight. A request made during a transfer is dropped, and the host is expected to wait for the acknowledge.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset, the chip enable output is high (inactive), the latch enables are low, both strobes are high, the write-protect release is low, the interrupt output is low and the mode register reads 0x00.
- R2: The mode byte at offset 4 reads back as written and drives the pins directly: bit 0 drives the command latch, bit 1 the address latch, bits 3:2 the power control pair, bit 4 chip enable (active-low pin = inverse of the bit), bits 6:5 the checker control pair, and bit 7 the write-protect release. For example, 0x94 is data mode, 0x95 is command mode, 0x96 is address mode and 0x00 is standby.
- R3: A 16-bit write to the data register at offset 0 issues exactly two write strobes. The first presents bits 7:0 and the second presents bits 15:8. The data is stable while the strobe is low.
- R4: An 8-bit write to the data register issues exactly one write strobe, carrying bits 7:0.
- R5: A 16-bit read of the data register issues two read strobes and returns the first fetched byte in bits 7:0 and the second in bits 15:8. An 8-bit read issues one strobe and returns the byte in bits 7:0 with bits 15:8 zero.
- R6: Every strobe stays low for exactly STROBE_LOW clock cycles (STROBE_LOW is at least 2), and the next strobe begins only after at least one high cycle.
- R7: Bit 7 of the status register at offset 5 reads 1 while the synchronised ready/busy input is low, and reads 0 when it is high. Its other bits read 0.
- R8: A rising edge of ready/busy sets bit 0 of the interrupt status register at offset 6. The interrupt output equals the OR of the status bits ANDed with the mask register bits 3:0 (mask at offset 7). A mask of 0x81 enables the interrupt and 0x00 disables it.
- R9: Interrupt status bits are write-1-to-clear. Writing 0x0F clears all of them, and writing 0x00 leaves them set.
- R10: The write and read strobes are never low together, and the data outputs are enabled whenever the write strobe is low.
- R11: Reads of the unused offsets 1, 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ack |
| irq | output | 1 | Ready interrupt |
| nand_io_out | output | 8 | Byte to the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the flash |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write-protect release (1 = writes allowed) |
| nand_pwr_ctl | output | 2 | Power control pair from mode bits 3:2 |
| nand_ecc_ctl | output | 2 | Checker control pair from mode bits 6:5 |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The mode register is swept over all 256 byte values, and every pin is compared with the bit it should follow, so a swapped or inverted field stands out. Data writes use a set of words whose high and low bytes differ (0xA55A, 0x1234, walking patterns, all-zero and all-one), so a reversed byte order or a lost second strobe shows in the flash-side log. Reads use an incrementing responder, so the first and second fetched bytes are distinguishable. Every strobe's low width is measured. The interrupt path is tried with the mask enabled and disabled, and with clear values of 0x00 and 0x0F, which separates latching, masking and write-1-to-clear behaviour.

// File: rtl/nand_bridge_pkg.sv
// Package: shared offsets, mode bit positions and sequencer states for the
// NAND host bridge. Assumes a byte-granular register map within 8 offsets.
package nand_bridge_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_ISR    = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_IMR    = 3'd7;

    localparam int MB_CLE   = 0;
    localparam int MB_ALE   = 1;
    localparam int MB_PWR_L = 2;
    localparam int MB_PWR_H = 3;
    localparam int MB_CE    = 4;
    localparam int MB_ECC_L = 5;
    localparam int MB_ECC_H = 6;
    localparam int MB_WREN  = 7;

    localparam int ISR_W = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2
    } seq_state_t;

endpackage

// File: rtl/nand_rb_sync.sv
// Module: two-flop synchroniser for the flash ready/busy line with rising
// edge detection. Assumes the line is asynchronous to clk. The flops reset to
// "ready" so that reset release never produces a false edge.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_level,
    output logic rb_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the asynchronous level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], rb_async};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rb_level = sync_q[STAGES-1];
    assign rb_rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nand_reg_bank.sv
// Module: mode, interrupt status and interrupt mask registers plus the
// register read mux for offsets other than the data register. Assumes
// byte-wide register writes taken from the low data byte.
module nand_reg_bank
    import nand_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    input  logic              rb_level,
    input  logic              rb_rise,
    output logic [7:0]        mode,
    output logic [7:0]        rd_byte,
    output logic [ISR_W-1:0]  isr_vec,
    output logic              irq
);
    logic [7:0]       mode_q;
    logic [7:0]       imr_q;
    logic [ISR_W-1:0] isr_q;
    logic [ISR_W-1:0] isr_set;

    assign isr_set = {{(ISR_W-1){1'b0}}, rb_rise};

    // Mode register: holds the control-line byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mode_q <= 8'h00;
        else if (wr_en && addr == OFF_MODE)  mode_q <= wbyte;
    end

    // Mask register: plain read/write byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                          imr_q <= 8'h00;
        else if (wr_en && addr == OFF_IMR)   imr_q <= wbyte;
    end

    // Interrupt status: set on events, write-1-to-clear, set wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else if (wr_en && addr == OFF_ISR)
            isr_q <= (isr_q & ~wbyte[ISR_W-1:0]) | isr_set;
        else
            isr_q <= isr_q | isr_set;
    end

    // Read mux for the byte registers; unused offsets read zero.
    always_comb begin
        unique case (addr)
            OFF_MODE:   rd_byte = mode_q;
            OFF_STATUS: rd_byte = {~rb_level, 7'd0};
            OFF_ISR:    rd_byte = {{(8-ISR_W){1'b0}}, isr_q};
            OFF_IMR:    rd_byte = imr_q;
            default:    rd_byte = 8'h00;
        endcase
    end

    assign mode    = mode_q;
    assign isr_vec = isr_q;
    assign irq     = |(isr_q & imr_q[ISR_W-1:0]);
endmodule

// File: rtl/nand_byte_seq.sv
// Module: splits a data access into one or two flash byte cycles and drives
// the read/write strobes. Each strobe is low for STROBE_LOW cycles and then
// high for one cycle. Read bytes are captured on the last low cycle. Assumes
// start is only pulsed while the sequencer is idle.
module nand_byte_seq
    import nand_bridge_pkg::*;
#(
    parameter int STROBE_LOW = 3,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic              two,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        io_in,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic              we_n,
    output logic              re_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int CW = (STROBE_LOW > 1) ? $clog2(STROBE_LOW) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_LOW - 1);

    seq_state_t        state_q;
    logic [CW-1:0]     cnt_q;
    logic              idx_q;
    logic              last_q;
    logic              rd_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              done_q;

    // Strobe state machine with low-time counter and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= 1'b0;
            last_q  <= 1'b0;
            rd_q    <= 1'b0;
            wdat_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start) begin
                    state_q <= SQ_LOW;
                    cnt_q   <= '0;
                    idx_q   <= 1'b0;
                    last_q  <= two;
                    rd_q    <= rd;
                    wdat_q  <= wdata;
                end
                SQ_LOW: begin
                    if (cnt_q == CNT_LAST) state_q <= SQ_HIGH;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                SQ_HIGH: begin
                    if (idx_q == last_q) state_q <= SQ_IDLE;
                    else begin
                        state_q <= SQ_LOW;
                        idx_q   <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Read data capture on the final low cycle of each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdat_q <= '0;
        else if (state_q == SQ_IDLE && start) rdat_q <= '0;
        else if (state_q == SQ_LOW && rd_q && cnt_q == CNT_LAST) begin
            if (idx_q) rdat_q[15:8] <= io_in;
            else       rdat_q[7:0]  <= io_in;
        end
    end

    // Completion pulse after the last byte's high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == SQ_HIGH) && (idx_q == last_q);
    end

    assign we_n   = !(state_q == SQ_LOW && !rd_q);
    assign re_n   = !(state_q == SQ_LOW && rd_q);
    assign io_out = idx_q ? wdat_q[15:8] : wdat_q[7:0];
    assign io_oe  = (state_q != SQ_IDLE) && !rd_q;
    assign busy   = (state_q != SQ_IDLE);
    assign done   = done_q;
    assign rdata  = rdat_q;
endmodule

// File: rtl/nand_host_bridge.sv
// Module: top of the NAND host bridge. It decodes host requests, runs
// register accesses in one cycle and passes data accesses to the byte
// sequencer. The mode byte drives the flash control pins. Assumes the host
// waits for host_ack before the next request; requests made while a data
// transfer is in flight are dropped.
module nand_host_bridge
    import nand_bridge_pkg::*;
#(
    parameter int STROBE_LOW = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic              host_ack,
    output logic [15:0]       host_rdata,
    output logic              irq,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [1:0]        nand_pwr_ctl,
    output logic [1:0]        nand_ecc_ctl,
    input  logic              nand_rb
);
    logic             accept;
    logic             is_data;
    logic             seq_busy;
    logic             seq_done;
    logic [15:0]      seq_rdata;
    logic             rb_level;
    logic             rb_rise;
    logic [7:0]       mode;
    logic [7:0]       reg_rd;
    logic [ISR_W-1:0] isr_vec;
    logic             ack_q;
    logic [15:0]      rdata_q;

    assign accept  = host_req && !seq_busy;
    assign is_data = (host_addr == OFF_DATA);

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .rb_level (rb_level),
        .rb_rise  (rb_rise)
    );

    nand_reg_bank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && host_we && !is_data),
        .addr     (host_addr),
        .wbyte    (host_wdata[7:0]),
        .rb_level (rb_level),
        .rb_rise  (rb_rise),
        .mode     (mode),
        .rd_byte  (reg_rd),
        .isr_vec  (isr_vec),
        .irq      (irq)
    );

    nand_byte_seq #(.STROBE_LOW(STROBE_LOW), .DATA_W(16)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && is_data),
        .rd     (!host_we),
        .two    (host_wide),
        .wdata  (host_wdata),
        .io_in  (nand_io_in),
        .io_out (nand_io_out),
        .io_oe  (nand_io_oe),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .busy   (seq_busy),
        .done   (seq_done),
        .rdata  (seq_rdata)
    );

    // Host acknowledge: one cycle after a register access, or on sequencer done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else if (seq_done) begin
            ack_q   <= 1'b1;
            rdata_q <= seq_rdata;
        end else if (accept && !is_data) begin
            ack_q   <= 1'b1;
            rdata_q <= {8'h00, reg_rd};
        end else begin
            ack_q   <= 1'b0;
        end
    end

    assign host_ack     = ack_q;
    assign host_rdata   = rdata_q;
    assign nand_cle     = mode[MB_CLE];
    assign nand_ale     = mode[MB_ALE];
    assign nand_ce_n    = ~mode[MB_CE];
    assign nand_wp_n    = mode[MB_WREN];
    assign nand_pwr_ctl = mode[MB_PWR_H:MB_PWR_L];
    assign nand_ecc_ctl = mode[MB_ECC_H:MB_ECC_L];
endmodule

// File: rtl/nand_host_bridge_chk.sv
// Checker: temporal properties of the bridge's flash-side strobes and its
// interrupt latch. It is attached to every instance of the top by bind.
module nand_host_bridge_chk #(
    parameter int ISR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nand_we_n,
    input logic             nand_re_n,
    input logic             nand_io_oe,
    input logic [7:0]       nand_io_out,
    input logic             rb_level,
    input logic [ISR_W-1:0] isr_vec
);
    // R10: strobes are mutually exclusive.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R10: output drivers are on while the write strobe is low.
    p_oe_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);

    // R6: a write strobe was low for at least two cycles before it rose.
    p_we_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (!$past(nand_we_n, 1) && !$past(nand_we_n, 2)));

    // R6: a read strobe was low for at least two cycles before it rose.
    p_re_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> (!$past(nand_re_n, 1) && !$past(nand_re_n, 2)));

    // R3: written byte holds steady during a low strobe.
    p_wdata_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_out));

    // R8: a rising ready level latches the ready-request bit.
    p_ready_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_level) |=> isr_vec[0]);
endmodule

bind nand_host_bridge nand_host_bridge_chk #(.ISR_W(nand_bridge_pkg::ISR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_oe  (nand_io_oe),
    .nand_io_out (nand_io_out),
    .rb_level    (rb_level),
    .isr_vec     (isr_vec)
);

// File: tb/nand_host_bridge_tb_top.sv
// Bench: drives the host bus, models the flash as a byte logger and an
// incrementing read responder, and compares against values computed here.
module nand_host_bridge_tb_top;
    localparam int L = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_wide = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic        irq;
    logic [7:0]  nand_io_out;
    logic        nand_io_oe;
    logic [7:0]  nand_io_in;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic [1:0]  nand_pwr_ctl, nand_ecc_ctl;
    logic        nand_rb = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nand_host_bridge #(.STROBE_LOW(L)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_wide(host_wide),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .irq(irq),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_pwr_ctl(nand_pwr_ctl), .nand_ecc_ctl(nand_ecc_ctl), .nand_rb(nand_rb)
    );

    // Flash model: write log and incrementing read value.
    logic [7:0] wlog [0:7];
    int         wcnt = 0;
    logic [7:0] rd_val = 8'h40;
    int         rcnt = 0;
    assign nand_io_in = rd_val;

    always @(posedge nand_we_n) if (rst_n) begin
        if (wcnt < 8) wlog[wcnt] = nand_io_out;
        wcnt = wcnt + 1;
    end
    always @(posedge nand_re_n) if (rst_n) begin
        rd_val = rd_val + 8'd1;
        rcnt = rcnt + 1;
    end

    // Strobe width monitor (R6): low runs must be exactly L, highs between.
    int we_run = 0, re_run = 0;
    always @(negedge clk) if (rst_n) begin
        if (!nand_we_n) we_run++;
        else if (we_run != 0) begin
            checks++;
            if (we_run != L) begin
                fails++;
                $display("FAIL R6 write strobe low width actual=%0d expected=%0d", we_run, L);
            end
            we_run = 0;
        end
        if (!nand_re_n) re_run++;
        else if (re_run != 0) begin
            checks++;
            if (re_run != L) begin
                fails++;
                $display("FAIL R6 read strobe low width actual=%0d expected=%0d", re_run, L);
            end
            re_run = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic wide, input logic [2:0] addr,
                          input logic [15:0] wd, output logic [15:0] rd);
        int guard;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wide = wide;
        host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        guard = 0;
        while (!host_ack && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        rd = host_rdata;
        if (guard >= 100) check("ack timeout", 32'd0, 32'd1);
    endtask

    logic [15:0] r;
    logic [15:0] wpat [0:7];

    initial begin
        wpat[0] = 16'hA55A; wpat[1] = 16'h1234; wpat[2] = 16'h0000; wpat[3] = 16'hFFFF;
        wpat[4] = 16'h0180; wpat[5] = 16'h8001; wpat[6] = 16'hFE7F; wpat[7] = 16'h00FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the pins and in the mode register.
        check("R1 ce_n", nand_ce_n, 1);
        check("R1 cle/ale", {nand_cle, nand_ale}, 0);
        check("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        check("R1 wp_n", nand_wp_n, 0);
        check("R1 irq", irq, 0);
        access(1'b0, 1'b0, 3'd4, 16'h0, r);
        check("R1 mode readback", r, 16'h0000);

        // R2: exhaustive mode byte sweep.
        for (int v = 0; v < 256; v++) begin
            logic [7:0] m;
            m = 8'(v);
            access(1'b1, 1'b0, 3'd4, {8'hEE, m}, r);
            @(negedge clk);
            check("R2 pins", {nand_wp_n, nand_ecc_ctl, ~nand_ce_n, nand_pwr_ctl, nand_ale, nand_cle}, {24'd0, m});
            access(1'b0, 1'b0, 3'd4, 16'h0, r);
            check("R2 readback", r, {24'd0, m});
        end
        access(1'b1, 1'b0, 3'd4, 16'h0095, r);
        @(negedge clk);
        check("R2 command mode", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
        access(1'b1, 1'b0, 3'd4, 16'h0096, r);
        @(negedge clk);
        check("R2 address mode", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
        access(1'b1, 1'b0, 3'd4, 16'h0094, r);
        @(negedge clk);
        check("R2 data mode", {nand_ce_n, nand_cle, nand_ale}, 3'b000);

        // R3: 16-bit writes, low byte first.
        for (int p = 0; p < 8; p++) begin
            wcnt = 0;
            access(1'b1, 1'b1, 3'd0, wpat[p], r);
            check("R3 strobe count", wcnt, 2);
            check("R3 first byte", wlog[0], {24'd0, wpat[p][7:0]});
            check("R3 second byte", wlog[1], {24'd0, wpat[p][15:8]});
        end

        // R4: 8-bit writes, one strobe.
        for (int p = 0; p < 4; p++) begin
            wcnt = 0;
            access(1'b1, 1'b0, 3'd0, wpat[p], r);
            check("R4 strobe count", wcnt, 1);
            check("R4 byte", wlog[0], {24'd0, wpat[p][7:0]});
        end

        // R5: 16-bit and 8-bit reads against the incrementing responder.
        for (int p = 0; p < 4; p++) begin
            logic [7:0] b0;
            b0 = rd_val;
            rcnt = 0;
            access(1'b0, 1'b1, 3'd0, 16'h0, r);
            check("R5 wide read", r, {16'd0, b0 + 8'd1, b0});
            check("R5 wide read strobes", rcnt, 2);
        end
        begin
            logic [7:0] b0;
            b0 = rd_val;
            rcnt = 0;
            access(1'b0, 1'b0, 3'd0, 16'h0, r);
            check("R5 narrow read", r, {24'd0, b0});
            check("R5 narrow read strobes", rcnt, 1);
        end

        // R11: unused offsets read zero.
        for (int a = 1; a < 4; a++) begin
            access(1'b0, 1'b0, 3'(a), 16'h0, r);
            check("R11 unused offset", r, 0);
        end

        // R7: busy flag follows the ready/busy line.
        access(1'b0, 1'b0, 3'd5, 16'h0, r);
        check("R7 ready status", r, 16'h0000);
        access(1'b1, 1'b0, 3'd6, 16'h000F, r);
        access(1'b1, 1'b0, 3'd7, 16'h0081, r);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b0, 1'b0, 3'd5, 16'h0, r);
        check("R7 busy status", r, 16'h0080);
        check("R8 no irq while busy", irq, 0);

        // R8: rising edge latches, mask enabled.
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 irq enabled", irq, 1);
        access(1'b0, 1'b0, 3'd6, 16'h0, r);
        check("R8 isr bit0", r, 16'h0001);

        // R8: masking with 0x00 hides the pending bit.
        access(1'b1, 1'b0, 3'd7, 16'h0000, r);
        @(negedge clk);
        check("R8 irq masked", irq, 0);
        access(1'b1, 1'b0, 3'd7, 16'h0081, r);
        @(negedge clk);
        check("R8 irq unmasked", irq, 1);

        // R9: writing zero leaves the bit, writing 0x0F clears it.
        access(1'b1, 1'b0, 3'd6, 16'h0000, r);
        access(1'b0, 1'b0, 3'd6, 16'h0, r);
        check("R9 zero write keeps", r, 16'h0001);
        access(1'b1, 1'b0, 3'd6, 16'h000F, r);
        access(1'b0, 1'b0, 3'd6, 16'h0, r);
        check("R9 clear", r, 16'h0000);
        @(negedge clk);
        check("R9 irq after clear", irq, 0);

        // R8: disabled mask, edge still latches but no interrupt.
        access(1'b1, 1'b0, 3'd7, 16'h0000, r);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 irq disabled", irq, 0);
        access(1'b0, 1'b0, 3'd6, 16'h0, r);
        check("R8 latched while masked", r, 16'h0001);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule